// File: doc/BRIEF.md
# Programmable Chip-Select Bus Timing Sequencer

This block runs read and write cycles on an external parallel bus for eight chip selects. Each chip select owns a 32-bit configuration word. The word holds an enable, a write permission, the data width, the address/data multiplexing choice, the cycle style and the size of the address window. It also holds the lengths of the five phases of every access. The phases always run in this order: address, setup, strobe, hold, recovery.

A host loads the configuration words through a plain write port. It then issues accesses through a valid/ready request stream that carries the chip-select index, byte address, direction and write data.

**Request back-pressure.** `req_ready` is high only while no bus cycle is in progress. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The host must hold the request fields steady until that edge.

**Response.** Every accepted request produces exactly one `rsp_valid` pulse, one cycle long. That pulse carries the read data and an error flag. The response has no ready signal, so the host must be able to take one response per access. The configuration of the selected chip select is frozen when the request is accepted.

Top module: `cs_bus_seq`

## Requirements
- R1: Eight configuration words are written through `cfg_we`/`cfg_sel`/`cfg_wdata`. All words reset to zero, so after reset every chip select is disabled.
- R2: A phase-length field value n gives n+1 clock cycles in that phase, and the phases run in the order address, setup, strobe, hold, recovery. The field positions are:
  - address length at bits 29:28
  - setup length at bits 27:26
  - strobe length at bits 25:22
  - hold length at bits 21:20
  - recovery length at bits 19:16
- R3: The selected active-low chip select, and only that one, is low from the first address cycle through the last hold cycle. All chip selects are high during recovery and when idle.
- R4: `bus_rd_n` is low for exactly the strobe phase of a read, and `bus_wr_n` is low for exactly the strobe phase of a write. The two are never low together.
- R5: Read data is sampled from `bus_din` on the last strobe cycle and returned with the response. When bit 0 (8-bit width) is set, only bits 7:0 are kept and the upper bits read as zero.
- R6: On a write, `bus_doe` is high and `bus_dout` carries the write data from the first setup cycle through the last hold cycle. In 8-bit mode the upper data bits are zero.
- R7: When bit 4 (multiplexed address/data) is set, `bus_doe` is high during the address phase and `bus_dout` carries the low address bits.
- R8: The size field at bits 13:10 sets a window of 512 << n bytes. `bus_addr` carries the request address modulo that window while the chip select is active, and zero otherwise.
- R9: A request fails if any of the following holds:
  - bit 31 (enable) is clear;
  - it is a write and bit 1 (write permit) is clear;
  - bits 15:14 (cycle style) are non-zero.
  A failed request completes with `rsp_valid` and `rsp_err` high in the cycle after acceptance, and it asserts no chip select, strobe or data enable.
- R10: A good request's `rsp_valid` pulse comes T cycles after acceptance, where T is the sum of the five phase lengths plus five. `rsp_err` is low with it, and `req_ready` is low from the first address cycle until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 3 | Configuration word index |
| cfg_wdata | input | 32 | Configuration word value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_cs | input | 3 | Target chip-select index |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused (with rsp_valid) |
| rsp_rdata | output | 16 | Read data (with rsp_valid) |
| bus_cs_n | output | 8 | Active-low chip selects |
| bus_addr | output | 24 | Bus address |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | 16 | Data or multiplexed address out |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | 16 | Data in from the bus |

## Verification
A phase counter that loads the wrong field, or that skips a reload, shows up within a single access. It changes the response latency, the number of cycles a chip select stays low, or the cycle index at which a strobe first falls. The bench counts each of these per access against lengths it computes from the configuration word. A wrong captured phase or register index shows up in the very next response: changing `bus_din` on every cycle makes a capture one cycle early or late return a visibly different word. A faulty error decode appears on the first cycle after acceptance, as a missing or spurious error pulse or a stray chip select.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STRB,
    PH_HOLD,
    PH_RECV
  } phase_e;

  typedef struct packed {
    logic [3:0] addr_len;
    logic [3:0] setup_len;
    logic [3:0] strb_len;
    logic [3:0] hold_len;
    logic [3:0] recv_len;
  } phase_len_t;

  typedef struct packed {
    logic       enable;
    logic       wr_ok;
    logic       narrow;
    logic       muxed;
    logic [1:0] style;
    logic [3:0] size;
    phase_len_t len;
  } cs_cfg_t;

  // Field placement inside a configuration word
  localparam int BIT_EN     = 31;
  localparam int BIT_WROK   = 1;
  localparam int BIT_NARROW = 0;
  localparam int BIT_MUX    = 4;

  function automatic cs_cfg_t unpack_cfg(input logic [31:0] w);
    cs_cfg_t c;
    c.enable        = w[BIT_EN];
    c.wr_ok         = w[BIT_WROK];
    c.narrow        = w[BIT_NARROW];
    c.muxed         = w[BIT_MUX];
    c.style         = w[15:14];
    c.size          = w[13:10];
    c.len.addr_len  = {2'b00, w[29:28]};
    c.len.setup_len = {2'b00, w[27:26]};
    c.len.strb_len  = w[25:22];
    c.len.hold_len  = {2'b00, w[21:20]};
    c.len.recv_len  = w[19:16];
    return c;
  endfunction

endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output cs_cfg_t          rd_cfg
);

  logic [31:0] words [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        words[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_cfg = unpack_cfg(words[rd_sel]);
  end

endmodule

// File: rtl/cs_req_check.sv
module cs_req_check
  import cs_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  cs_cfg_t            cfg,
  input  logic               is_write,
  input  logic [ADDR_W-1:0]  addr_in,
  output logic               refuse,
  output logic [ADDR_W-1:0]  addr_out
);

  localparam int BASE_SHIFT = 9;

  logic [ADDR_W:0] window;
  logic [ADDR_W:0] win_mask;

  always_comb begin
    window   = (ADDR_W+1)'(1) << (BASE_SHIFT + int'(cfg.size));
    win_mask = window - (ADDR_W+1)'(1);
    addr_out = addr_in & win_mask[ADDR_W-1:0];
    refuse   = !cfg.enable || (is_write && !cfg.wr_ok) || (cfg.style != 2'b00);
  end

endmodule

// File: rtl/cs_phase_seq.sv
module cs_phase_seq
  import cs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  phase_len_t len_in,
  output phase_e     phase,
  output logic       last_cyc,
  output logic       done
);

  phase_len_t lens;
  logic [3:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      lens  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_ADDR;
            cnt   <= len_in.addr_len;
            lens  <= len_in;
          end
        end
        PH_ADDR: begin
          if (cnt == 4'd0) begin
            phase <= PH_SETUP;
            cnt   <= lens.setup_len;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        PH_SETUP: begin
          if (cnt == 4'd0) begin
            phase <= PH_STRB;
            cnt   <= lens.strb_len;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        PH_STRB: begin
          if (cnt == 4'd0) begin
            phase <= PH_HOLD;
            cnt   <= lens.hold_len;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        PH_HOLD: begin
          if (cnt == 4'd0) begin
            phase <= PH_RECV;
            cnt   <= lens.recv_len;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        PH_RECV: begin
          if (cnt == 4'd0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 4'd1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign last_cyc = (cnt == 4'd0);

  // R2: each phase is entered only from its predecessor
  a_r2_setup_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP && $past(phase) != PH_SETUP) |-> $past(phase) == PH_ADDR);
  a_r2_strb_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STRB && $past(phase) != PH_STRB) |-> $past(phase) == PH_SETUP);
  a_r2_hold_after_strb: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && $past(phase) != PH_HOLD) |-> $past(phase) == PH_STRB);
  a_r2_recv_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECV && $past(phase) != PH_RECV) |-> $past(phase) == PH_HOLD);
  // R10: completion follows the recovery phase
  a_r10_done_from_recv: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE && $past(phase) == PH_RECV));

endmodule

// File: rtl/cs_bus_seq.sv
module cs_bus_seq
  import cs_seq_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);

  localparam int NARROW_W = 8;

  cs_cfg_t           sel_cfg;
  logic              refuse;
  logic [ADDR_W-1:0] win_addr;
  phase_e            phase;
  logic              last_cyc;
  logic              seq_done;
  logic              accept;
  logic              start;

  logic [SEL_W-1:0]  cur_cs;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_write;
  logic              cur_narrow;
  logic              cur_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              refuse_pulse;

  cs_cfg_bank #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .rd_sel  (req_cs),
    .rd_cfg  (sel_cfg)
  );

  cs_req_check #(.ADDR_W(ADDR_W)) u_check (
    .cfg      (sel_cfg),
    .is_write (req_write),
    .addr_in  (req_addr),
    .refuse   (refuse),
    .addr_out (win_addr)
  );

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign start     = accept && !refuse;

  cs_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len_in   (sel_cfg.len),
    .phase    (phase),
    .last_cyc (last_cyc),
    .done     (seq_done)
  );

  function automatic logic [DATA_W-1:0] trim(input logic [DATA_W-1:0] d, input logic nar);
    return nar ? {{(DATA_W-NARROW_W){1'b0}}, d[NARROW_W-1:0]} : d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cs       <= '0;
      cur_addr     <= '0;
      cur_wdata    <= '0;
      cur_write    <= 1'b0;
      cur_narrow   <= 1'b0;
      cur_mux      <= 1'b0;
      rdata_q      <= '0;
      refuse_pulse <= 1'b0;
    end else begin
      refuse_pulse <= accept && refuse;
      if (accept) begin
        rdata_q <= '0;
      end
      if (start) begin
        cur_cs     <= req_cs;
        cur_addr   <= win_addr;
        cur_wdata  <= trim(req_wdata, sel_cfg.narrow);
        cur_write  <= req_write;
        cur_narrow <= sel_cfg.narrow;
        cur_mux    <= sel_cfg.muxed;
      end
      if (phase == PH_STRB && last_cyc && !cur_write) begin
        rdata_q <= trim(bus_din, cur_narrow);
      end
    end
  end

  logic active;
  logic drive_data;
  logic drive_addr;

  always_comb begin
    active     = (phase == PH_ADDR) || (phase == PH_SETUP) ||
                 (phase == PH_STRB) || (phase == PH_HOLD);
    drive_data = cur_write && ((phase == PH_SETUP) || (phase == PH_STRB) ||
                               (phase == PH_HOLD));
    drive_addr = cur_mux && (phase == PH_ADDR);
    bus_cs_n   = active ? ~(NUM_CS'(1) << cur_cs) : '1;
    bus_addr   = active ? cur_addr : '0;
    bus_rd_n   = !((phase == PH_STRB) && !cur_write);
    bus_wr_n   = !((phase == PH_STRB) && cur_write);
    bus_doe    = drive_data || drive_addr;
    if (drive_addr)      bus_dout = cur_addr[DATA_W-1:0];
    else if (drive_data) bus_dout = cur_wdata;
    else                 bus_dout = '0;
  end

  assign rsp_valid = seq_done || refuse_pulse;
  assign rsp_err   = refuse_pulse;
  assign rsp_rdata = rdata_q;

  // R4: never both strobes low
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));
  // R4: a strobe only inside an active chip select
  a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> (bus_cs_n != '1));
  // R3: at most one chip select low
  a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  // R9: refused request drives no chip select next cycle
  a_r9_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && refuse) |=> (bus_cs_n == '1 && bus_rd_n && bus_wr_n && !bus_doe));
  // R10: a good request makes the block busy
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !refuse) |=> !req_ready);

endmodule

// File: tb/tb_cs_bus_seq.sv
module tb_cs_bus_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cs = '0;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [7:0]  bus_cs_n;
  logic [23:0] bus_addr;
  logic        bus_rd_n, bus_wr_n, bus_doe;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;

  int errors = 0;
  int checks = 0;
  logic [31:0] shadow [8];

  always #2 clk = ~clk;

  cs_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  task automatic chk(input logic ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(input logic en, input logic wp, input logic w8,
      input logic mx, input logic [1:0] sty, input logic [3:0] sz, input logic [1:0] a,
      input logic [1:0] s, input logic [3:0] st, input logic [1:0] h, input logic [3:0] r);
    return {en, 1'b0, a, s, st, h, r, sty, sz, 5'b0, mx, 2'b0, wp, w8};
  endfunction

  task automatic put_cfg(input int idx, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(idx); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[idx] = w;
  endtask

  // Runs one access and checks every observable rule against the shadow word
  task automatic access(input int cs, input logic [23:0] addr, input logic wr, input logic [15:0] wd);
    logic [31:0] c;
    logic experr, w8, mx;
    int a, s, st, h, r, tot, n, lat;
    int cs_cyc, cs_bad, rd_cyc, wr_cyc, first_strb, addr_bad, doe_cyc, doe_bad;
    logic [15:0] last_din, exp_wd, exp_rd;
    logic [23:0] exp_addr;
    logic got_err, busy_ok;
    logic [15:0] got_rd;
    c = shadow[cs];
    w8 = c[0]; mx = c[4];
    a = int'(c[29:28]); s = int'(c[27:26]); st = int'(c[25:22]);
    h = int'(c[21:20]); r = int'(c[19:16]);
    experr = !c[31] || (wr && !c[1]) || (c[15:14] != 2'b00);
    tot = a + s + st + h + r + 5;
    exp_addr = addr & 24'((25'd1 << (9 + int'(c[13:10]))) - 25'd1);
    exp_wd = w8 ? {8'h00, wd[7:0]} : wd;
    cs_cyc = 0; cs_bad = 0; rd_cyc = 0; wr_cyc = 0; first_strb = -1;
    addr_bad = 0; doe_cyc = 0; doe_bad = 0; lat = -1; last_din = '0;
    got_err = 1'b0; got_rd = '0; busy_ok = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
    req_valid = 1'b1; req_cs = 3'(cs); req_addr = addr; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (n = 1; n < 300; n++) begin
      bus_din = 16'(n * 16'h0137 + 16'h2A5C);
      if (rsp_valid) begin
        lat = n - 1; got_err = rsp_err; got_rd = rsp_rdata;
        break;
      end
      if (n == 1 && req_ready) busy_ok = 1'b0;
      if (bus_cs_n != 8'hFF) begin
        cs_cyc++;
        if (bus_cs_n != ~(8'd1 << cs)) cs_bad++;
        if (bus_addr != exp_addr) addr_bad++;
      end
      if (!bus_rd_n) begin
        rd_cyc++; last_din = bus_din;
        if (first_strb < 0) first_strb = n;
      end
      if (!bus_wr_n) begin
        wr_cyc++;
        if (first_strb < 0) first_strb = n;
      end
      if (bus_doe) begin
        doe_cyc++;
        if (n <= a + 1) begin
          if (bus_dout != exp_addr[15:0]) doe_bad++;
        end else if (bus_dout != exp_wd) doe_bad++;
      end
      @(negedge clk);
    end
    chk(lat >= 0, "R10 response seen (timeout)", lat, tot);
    if (experr) begin
      chk(lat == 0, "R9 error latency", lat, 0);
      chk(got_err == 1'b1, "R9 error flag", got_err, 1);
      chk(cs_cyc == 0 && rd_cyc == 0 && wr_cyc == 0 && doe_cyc == 0,
          "R9 no bus activity", cs_cyc + rd_cyc + wr_cyc + doe_cyc, 0);
    end else begin
      chk(lat == tot, "R10 latency", lat, tot);
      chk(got_err == 1'b0, "R10 no error", got_err, 0);
      chk(busy_ok, "R10 ready low while busy", busy_ok, 1);
      chk(cs_cyc == a + s + st + h + 4, "R3 chip-select cycles", cs_cyc, a + s + st + h + 4);
      chk(cs_bad == 0, "R3 correct chip select", cs_bad, 0);
      chk(addr_bad == 0, "R8 windowed address", addr_bad, 0);
      chk(first_strb == a + s + 3, "R2 strobe start cycle", first_strb, a + s + 3);
      if (wr) chk(wr_cyc == st + 1 && rd_cyc == 0, "R4 write strobe cycles", wr_cyc * 256 + rd_cyc, (st + 1) * 256);
      else    chk(rd_cyc == st + 1 && wr_cyc == 0, "R4 read strobe cycles", rd_cyc * 256 + wr_cyc, (st + 1) * 256);
      chk(doe_cyc == (mx ? a + 1 : 0) + (wr ? s + st + h + 3 : 0), "R6 R7 output enable cycles",
          doe_cyc, (mx ? a + 1 : 0) + (wr ? s + st + h + 3 : 0));
      chk(doe_bad == 0, "R6 R7 driven value", doe_bad, 0);
      if (!wr) begin
        exp_rd = w8 ? {8'h00, last_din[7:0]} : last_din;
        chk(got_rd == exp_rd, "R5 read data", got_rd, exp_rd);
      end
    end
  endtask

  task automatic t_reset;
    chk(bus_cs_n == 8'hFF && bus_rd_n && bus_wr_n && !bus_doe, "R3 idle pins after reset",
        {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe}, 11'h7FE);
    chk(req_ready && !rsp_valid, "R10 reset handshake", {req_ready, rsp_valid}, 2'b10);
    access(0, 24'h000010, 1'b0, 16'h0);   // R1: unprogrammed word refuses
  endtask

  task automatic t_read_basic;
    put_cfg(2, mkcfg(1, 0, 0, 0, 0, 15, 1, 2, 3, 1, 2));
    access(2, 24'h123456, 1'b0, 16'h0);   // R2 R3 R4 R5
  endtask

  task automatic t_min_max;
    put_cfg(5, mkcfg(1, 1, 0, 0, 0, 15, 0, 0, 0, 0, 0));
    access(5, 24'h00ABCD, 1'b0, 16'h0);   // R2 shortest
    put_cfg(7, mkcfg(1, 1, 0, 0, 0, 15, 3, 3, 15, 3, 15));
    access(7, 24'hFEDCBA, 1'b1, 16'hBEEF); // R2 longest write
  endtask

  task automatic t_write;
    put_cfg(1, mkcfg(1, 1, 0, 0, 0, 15, 2, 1, 2, 2, 1));
    access(1, 24'h0F0F0F, 1'b1, 16'hA55A); // R6
  endtask

  task automatic t_mux;
    put_cfg(3, mkcfg(1, 1, 0, 1, 0, 15, 2, 0, 1, 0, 3));
    access(3, 24'h3C9876, 1'b0, 16'h0);   // R7 read
    access(3, 24'h001234, 1'b1, 16'h7E81); // R7 write
  endtask

  task automatic t_narrow;
    put_cfg(4, mkcfg(1, 1, 1, 0, 0, 15, 0, 1, 2, 1, 0));
    access(4, 24'h000321, 1'b0, 16'h0);   // R5 8-bit read
    access(4, 24'h000322, 1'b1, 16'hC3F0); // R6 8-bit write
  endtask

  task automatic t_window;
    put_cfg(6, mkcfg(1, 0, 0, 0, 0, 2, 0, 0, 1, 0, 0));
    access(6, 24'hABCDEF, 1'b0, 16'h0);   // R8 2 KB window
    put_cfg(6, mkcfg(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
    access(6, 24'hABCDEF, 1'b0, 16'h0);   // R8 512 B window
  endtask

  task automatic t_errors;
    put_cfg(0, mkcfg(0, 1, 0, 0, 0, 15, 1, 1, 1, 1, 1));
    access(0, 24'h000100, 1'b0, 16'h0);   // R9 disabled
    put_cfg(0, mkcfg(1, 0, 0, 0, 0, 15, 1, 1, 1, 1, 1));
    access(0, 24'h000100, 1'b1, 16'h1111); // R9 write protected
    access(0, 24'h000100, 1'b0, 16'h0);   // R9 read still allowed
    put_cfg(0, mkcfg(1, 1, 0, 0, 2'b01, 15, 1, 1, 1, 1, 1));
    access(0, 24'h000100, 1'b0, 16'h0);   // R9 unsupported style
  endtask

  initial begin
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_basic;
    t_min_max;
    t_write;
    t_mux;
    t_narrow;
    t_window;
    t_errors;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule